// File: doc/BRIEF.md
# Multi-Mode Test Word Generator

This block sits in one converter channel's output path, just before serialization. It can replace the channel's 12-bit sample stream with a known test word. A 4-bit select chooses the source. Code 0 passes the normal data through unchanged. The other codes choose fixed levels, alternating words, two pseudo-random sequences, or two user-supplied words that play according to a 2-bit sequencing field.

A sample-clock enable sets the pace. On each cycle where the enable is high, the block registers one output word, and the valid flag is high in the following cycle. The long (23-stage) and short (9-stage) pseudo-random generators each have their own reset strobe, so a receiver can realign either one without disturbing the other. In the play-once sequencing variants, the user pattern is emitted a single time and the output then stays at zero. Any change to the select or sequencing inputs re-arms the pattern. That same change also restarts every alternating pattern at its first word.

Top module: `test_pattern_gen`

## Requirements
- R1: While reset is asserted, `data_out` is 0x000 and `data_valid` is 0.
- R2: `data_valid` in each cycle equals `sample_en` from the previous cycle. `data_out` changes only at a clock edge where `sample_en` was high, and otherwise holds its value.
- R3: Select code 0, and the unassigned codes 13, 14 and 15, register `data_in` unchanged.
- R4: The fixed codes produce these words: 1 → 0x800, 2 → 0xFFF, 3 → 0x000, 9 → 0xAAA, 10 → 0x03F, 11 → 0x800, 12 → 0xA0F.
- R5: Code 4 alternates 0xAAA and 0x555, and code 7 alternates 0xFFF and 0x000. Each alternating pattern advances one word per enabled sample and starts with its first word (0xAAA or 0xFFF) after any change to `test_mode` or `user_seq`.
- R6: Code 5 emits the long sequence. It is a 23-stage shift register with feedback bit = stage23 XOR stage18, and its state shifts toward stage 23 as the feedback enters stage 1. Each output word holds the next 12 feedback bits, the first one in bit 11. The state advances only on enabled samples while code 5 is selected.
- R7: Code 6 emits the short sequence in the same way. It is a 9-stage register with feedback = stage9 XOR stage5, 12 bits per word, first bit in bit 11, and it advances only on enabled samples while code 6 is selected.
- R8: `pn_long_rst` loads all ones into the long generator, and `pn_short_rst` loads all ones into the short one. Neither affects the other generator. If a strobe is high during an enabled sample of its own code, that sample's word is taken from the all-ones seed.
- R9: Under code 8, `user_seq` = 0 repeats `user_word_a`, and `user_seq` = 1 alternates `user_word_a` and `user_word_b`, starting with `user_word_a` after any select change.
- R10: Under code 8, `user_seq` = 2 emits `user_word_a` once, and `user_seq` = 3 emits `user_word_a` then `user_word_b`. After that, every enabled sample gives 0x000 until `test_mode` or `user_seq` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One output word is produced per high cycle |
| test_mode | input | 4 | Source select code |
| user_seq | input | 2 | User word sequencing field |
| user_word_a | input | 12 | First user word |
| user_word_b | input | 12 | Second user word |
| pn_long_rst | input | 1 | Reseed strobe for the 23-stage generator |
| pn_short_rst | input | 1 | Reseed strobe for the 9-stage generator |
| data_in | input | 12 | Normal converter samples |
| data_out | output | 12 | Registered output word |
| data_valid | output | 1 | High one cycle after an enabled sample |

## Verification
The hardest behaviour to reach from the ports is how the play-once counters and the alternation phase interact with select changes. The first word after a change must be correct even when the change and an enabled sample fall in the same cycle. A generator's state must also survive while other codes are active. To reach this, the stimulus switches between codes and sequencing values back to back with a random enable. It returns to the pseudo-random codes after detours, and it fires each reseed strobe both while its own code is selected and while the other generator's code is selected.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   typedef enum logic [3:0] {
      TM_OFF    = 4'd0,
      TM_MID    = 4'd1,
      TM_PFS    = 4'd2,
      TM_NFS    = 4'd3,
      TM_CHECK  = 4'd4,
      TM_PN23   = 4'd5,
      TM_PN9    = 4'd6,
      TM_WTOG   = 4'd7,
      TM_USER   = 4'd8,
      TM_BTOG   = 4'd9,
      TM_SYNC   = 4'd10,
      TM_ONEBIT = 4'd11,
      TM_MIXED  = 4'd12
   } tmode_e;

   typedef enum logic [1:0] {
      US_SINGLE      = 2'd0,
      US_ALT         = 2'd1,
      US_SINGLE_ONCE = 2'd2,
      US_ALT_ONCE    = 2'd3
   } useq_e;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
   parameter int LEN   = 23,
   parameter int TAP   = 18,
   parameter int OUT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_i,
   input  logic             step_i,
   output logic [OUT_W-1:0] word_o
);
   generate
      if (TAP < 1 || TAP >= LEN || LEN < 2) begin : g_bad_taps
         $error("tpg_lfsr: TAP must lie strictly between 0 and LEN");
      end
   endgenerate

   logic [LEN-1:0] state_q;
   logic [LEN-1:0] chain [0:OUT_W];

   assign chain[0] = seed_i ? {LEN{1'b1}} : state_q;

   generate
      for (genvar k = 0; k < OUT_W; k++) begin : g_step
         logic fb;
         assign fb           = chain[k][LEN-1] ^ chain[k][TAP-1];
         assign chain[k+1]   = {chain[k][LEN-2:0], fb};
         assign word_o[OUT_W-1-k] = fb;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= {LEN{1'b1}};
      else if (step_i) state_q <= chain[OUT_W];
      else if (seed_i) state_q <= {LEN{1'b1}};
   end

   // R6 / R7: a maximal-length register seeded non-zero never reaches zero
   p_state_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
   // R8: a strobe without an advance leaves exactly the seed
   p_seed_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seed_i && !step_i |=> state_q == {LEN{1'b1}});
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq #(
   parameter int SEL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             step_i,
   output logic             phase_o,
   output logic [1:0]       count_o
);
   localparam logic [1:0] CNT_MAX = 2'd2;

   logic [SEL_W-1:0] sel_q;
   logic             phase_q;
   logic [1:0]       cnt_q;
   logic             changed;

   assign changed = (sel_i != sel_q);
   assign phase_o = changed ? 1'b0 : phase_q;
   assign count_o = changed ? 2'd0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         phase_q <= 1'b0;
         cnt_q   <= 2'd0;
      end else begin
         sel_q <= sel_i;
         if (step_i) begin
            phase_q <= ~phase_o;
            cnt_q   <= (count_o == CNT_MAX) ? CNT_MAX : count_o + 2'd1;
         end else begin
            phase_q <= phase_o;
            cnt_q   <= count_o;
         end
      end
   end

   // R10: the play counter never exceeds its saturation value
   p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
   // R10: once exhausted, it stays exhausted while the select is unchanged
   p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q == CNT_MAX && !changed |=> cnt_q == CNT_MAX);
   // R5: a select change restarts the alternation phase
   p_phase_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      changed && !step_i |=> !phase_q);
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
   parameter int DATA_W    = 12,
   parameter int LONG_LEN  = 23,
   parameter int LONG_TAP  = 18,
   parameter int SHORT_LEN = 9,
   parameter int SHORT_TAP = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic [3:0]        test_mode,
   input  logic [1:0]        user_seq,
   input  logic [DATA_W-1:0] user_word_a,
   input  logic [DATA_W-1:0] user_word_b,
   input  logic              pn_long_rst,
   input  logic              pn_short_rst,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_valid
);
   import tpg_pkg::*;

   generate
      if (DATA_W < 6 || (DATA_W % 6) != 0) begin : g_bad_width
         $error("test_pattern_gen: DATA_W must be a positive multiple of 6");
      end
   endgenerate

   localparam int THIRD = DATA_W / 3;
   localparam int HALF  = DATA_W / 2;

   function automatic logic [DATA_W-1:0] odd_bits();
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W; i++) r[i] = (i % 2) == 1;
      return r;
   endfunction

   function automatic logic [DATA_W-1:0] mixed_bits();
      logic [DATA_W-1:0] r;
      r = '0;
      for (int j = 0; j < THIRD; j++) begin
         r[DATA_W-1-j] = (j % 2) == 0;
         r[j]          = 1'b1;
      end
      return r;
   endfunction

   localparam logic [DATA_W-1:0] P_MID   = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] P_FULL  = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] P_ZERO  = {DATA_W{1'b0}};
   localparam logic [DATA_W-1:0] P_CHK   = odd_bits();
   localparam logic [DATA_W-1:0] P_SYNC  = {{HALF{1'b0}}, {HALF{1'b1}}};
   localparam logic [DATA_W-1:0] P_MIXED = mixed_bits();

   logic              long_step, short_step;
   logic [DATA_W-1:0] long_word, short_word;
   logic              phase;
   logic [1:0]        count;
   logic [DATA_W-1:0] user_word;
   logic [DATA_W-1:0] next_word;

   assign long_step  = sample_en && (test_mode == TM_PN23);
   assign short_step = sample_en && (test_mode == TM_PN9);

   tpg_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP), .OUT_W(DATA_W)) u_long (
      .clk    (clk),
      .rst_n  (rst_n),
      .seed_i (pn_long_rst),
      .step_i (long_step),
      .word_o (long_word)
   );

   tpg_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .OUT_W(DATA_W)) u_short (
      .clk    (clk),
      .rst_n  (rst_n),
      .seed_i (pn_short_rst),
      .step_i (short_step),
      .word_o (short_word)
   );

   tpg_seq #(.SEL_W(6)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   ({test_mode, user_seq}),
      .step_i  (sample_en),
      .phase_o (phase),
      .count_o (count)
   );

   always_comb begin
      unique case (user_seq)
         US_SINGLE:      user_word = user_word_a;
         US_ALT:         user_word = phase ? user_word_b : user_word_a;
         US_SINGLE_ONCE: user_word = (count == 2'd0) ? user_word_a : P_ZERO;
         default:        user_word = (count == 2'd0) ? user_word_a :
                                     (count == 2'd1) ? user_word_b : P_ZERO;
      endcase
   end

   always_comb begin
      case (test_mode)
         TM_MID:    next_word = P_MID;
         TM_PFS:    next_word = P_FULL;
         TM_NFS:    next_word = P_ZERO;
         TM_CHECK:  next_word = phase ? ~P_CHK : P_CHK;
         TM_PN23:   next_word = long_word;
         TM_PN9:    next_word = short_word;
         TM_WTOG:   next_word = phase ? P_ZERO : P_FULL;
         TM_USER:   next_word = user_word;
         TM_BTOG:   next_word = P_CHK;
         TM_SYNC:   next_word = P_SYNC;
         TM_ONEBIT: next_word = P_MID;
         TM_MIXED:  next_word = P_MIXED;
         default:   next_word = data_in;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out   <= '0;
         data_valid <= 1'b0;
      end else begin
         data_valid <= sample_en;
         if (sample_en) data_out <= next_word;
      end
   end

   p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> data_valid);
   p_valid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> !data_valid);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable(data_out));
   p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en && test_mode == 4'd0 |=> data_out == $past(data_in));
   p_fullscale_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en && test_mode == 4'd2 |=> data_out == P_FULL);
endmodule

// File: tb/test_pattern_gen_test.sv
module test_pattern_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_en = 1'b0;
   logic [3:0]  test_mode = 4'd0;
   logic [1:0]  user_seq = 2'd0;
   logic [11:0] user_word_a = 12'h0;
   logic [11:0] user_word_b = 12'h0;
   logic        pn_long_rst = 1'b0;
   logic        pn_short_rst = 1'b0;
   logic [11:0] data_in = 12'h0;
   logic [11:0] data_out;
   logic        data_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   logic [11:0] exp_out;
   logic        exp_valid;
   logic [5:0]  m_prev;
   logic        m_phase;
   int          m_cnt;
   logic [31:0] m_s23, m_s9;
   string       exp_tag;

   always #2 clk = ~clk;

   test_pattern_gen uut (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .test_mode(test_mode),
      .user_seq(user_seq), .user_word_a(user_word_a), .user_word_b(user_word_b),
      .pn_long_rst(pn_long_rst), .pn_short_rst(pn_short_rst),
      .data_in(data_in), .data_out(data_out), .data_valid(data_valid));

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] pn_word(input int len, input int tap, inout logic [31:0] st);
      logic [11:0] w = 12'h0;
      logic [31:0] mask = (32'h1 << len) - 1;
      for (int k = 0; k < 12; k++) begin
         logic fb;
         fb = st[len-1] ^ st[tap-1];
         st = ((st << 1) | {31'h0, fb}) & mask;
         w  = {w[10:0], fb};
      end
      return w;
   endfunction

   task automatic model_reset();
      exp_out = 12'h0; exp_valid = 1'b0; m_prev = 6'h0; m_phase = 1'b0;
      m_cnt = 0; m_s23 = 32'h7FFFFF; m_s9 = 32'h1FF; exp_tag = "R1";
   endtask

   // apply current inputs to the model for the coming edge
   task automatic model_step();
      bit          chg;
      logic        ph;
      int          ct;
      logic [31:0] l23, l9, t;
      logic [11:0] w;
      chg = ({test_mode, user_seq} != m_prev);
      ph  = chg ? 1'b0 : m_phase;
      ct  = chg ? 0 : m_cnt;
      l23 = pn_long_rst  ? 32'h7FFFFF : m_s23;
      l9  = pn_short_rst ? 32'h1FF    : m_s9;
      case (test_mode)
         4'd1, 4'd11: begin w = 12'h800; exp_tag = "R4"; end
         4'd2:  begin w = 12'hFFF; exp_tag = "R4"; end
         4'd3:  begin w = 12'h000; exp_tag = "R4"; end
         4'd9:  begin w = 12'hAAA; exp_tag = "R4"; end
         4'd10: begin w = 12'h03F; exp_tag = "R4"; end
         4'd12: begin w = 12'hA0F; exp_tag = "R4"; end
         4'd4:  begin w = ph ? 12'h555 : 12'hAAA; exp_tag = "R5"; end
         4'd7:  begin w = ph ? 12'h000 : 12'hFFF; exp_tag = "R5"; end
         4'd5: begin
            t = l23; w = pn_word(23, 18, t);
            if (sample_en) l23 = t;
            exp_tag = pn_long_rst ? "R8" : "R6";
         end
         4'd6: begin
            t = l9; w = pn_word(9, 5, t);
            if (sample_en) l9 = t;
            exp_tag = pn_short_rst ? "R8" : "R7";
         end
         4'd8: begin
            case (user_seq)
               2'd0: w = user_word_a;
               2'd1: w = ph ? user_word_b : user_word_a;
               2'd2: w = (ct == 0) ? user_word_a : 12'h000;
               default: w = (ct == 0) ? user_word_a : (ct == 1) ? user_word_b : 12'h000;
            endcase
            exp_tag = user_seq[1] ? "R10" : "R9";
         end
         default: begin w = data_in; exp_tag = "R3"; end
      endcase
      m_s23 = l23; m_s9 = l9;
      if (sample_en) begin
         exp_out = w;
         m_phase = ~ph;
         m_cnt   = (ct == 2) ? 2 : ct + 1;
      end else begin
         m_phase = ph;
         m_cnt   = ct;
      end
      exp_valid = sample_en;
      m_prev = {test_mode, user_seq};
   endtask

   // one cycle: compare previous edge's result, drive, update model
   task automatic cycle(input logic [3:0] mode, input logic [1:0] sq, input int en_pct,
                        input int lr_pct, input int sr_pct);
      @(negedge clk);
      check("R2", {11'h0, data_valid}, {11'h0, exp_valid});
      check(exp_tag, data_out, exp_out);
      test_mode    = mode;
      user_seq     = sq;
      sample_en    = ($urandom_range(99) < en_pct);
      pn_long_rst  = ($urandom_range(99) < lr_pct);
      pn_short_rst = ($urandom_range(99) < sr_pct);
      data_in      = 12'($urandom);
      if ($urandom_range(9) == 0) user_word_a = 12'($urandom);
      if ($urandom_range(9) == 0) user_word_b = 12'($urandom);
      model_step();
   endtask

   task automatic seg(input logic [3:0] mode, input logic [1:0] sq, input int n,
                      input int en_pct, input int lr_pct, input int sr_pct);
      for (int i = 0; i < n; i++) cycle(mode, sq, en_pct, lr_pct, sr_pct);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      user_word_a = 12'h5C3;
      user_word_b = 12'h2B1;
      sample_en = 1'b1;
      test_mode = 4'd2;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs held at zero during reset despite active inputs
      check("R1", data_out, 12'h000);
      check("R1", {11'h0, data_valid}, 12'h000);
      sample_en = 1'b0; test_mode = 4'd0;
      rst_n = 1'b1;
      model_step();
      // every code, every sequencing value under code 8
      for (int m = 0; m < 16; m++) begin
         if (m == 8) begin
            for (int s = 0; s < 4; s++) seg(4'(m), 2'(s), 30, 70, 0, 0);
         end else begin
            seg(4'(m), 2'd0, 30, 70, 0, 0);
         end
      end
      // R6 R7 R8: generators, detours, independent reseeds
      seg(4'd5, 2'd0, 40, 80, 0, 0);
      seg(4'd4, 2'd0, 10, 80, 0, 0);
      seg(4'd5, 2'd0, 40, 80, 8, 8);
      seg(4'd6, 2'd0, 40, 80, 8, 0);
      seg(4'd6, 2'd0, 40, 80, 0, 8);
      seg(4'd5, 2'd0, 40, 60, 0, 10);
      seg(4'd0, 2'd0, 10, 50, 20, 20);
      seg(4'd6, 2'd0, 30, 100, 0, 0);
      seg(4'd5, 2'd0, 30, 100, 0, 0);
      // R10: play-once re-arm by changes, back to back
      seg(4'd8, 2'd2, 12, 100, 0, 0);
      seg(4'd8, 2'd3, 12, 100, 0, 0);
      seg(4'd8, 2'd2, 12, 40, 0, 0);
      seg(4'd7, 2'd2, 3, 100, 0, 0);
      seg(4'd8, 2'd3, 12, 40, 0, 0);
      // R5 R9: rapid select flipping with random enables
      for (int i = 0; i < 300; i++)
         cycle(4'($urandom_range(15)), 2'($urandom_range(3)), 60, 5, 5);
      for (int i = 0; i < 200; i++)
         cycle(($urandom_range(1) == 1) ? 4'd8 : 4'd4, 2'($urandom_range(3)), 50, 0, 0);
      seg(4'd0, 2'd0, 2, 0, 0, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule